// File: doc/BRIEF.md
# Code-Block Slot Sequencer with Slot Duplication

This block takes fixed-size code blocks and turns each one into an ordered stream of executable instructions. A block is 256 bits wide and holds eight 32-bit slots, numbered 0 to 7. Bit 16 of a slot tells whether the slot holds one 32-bit instruction or a pair of 16-bit instructions. A 3-bit field in the low bits of an operate instruction has two meanings. In slot 0 it says how many trailing slots hold pseudo-immediate data instead of code. In any later slot it names another slot, and a copy of that slot's instruction is issued right after the pointing instruction.

A block arrives over a valid/ready handshake. Instructions leave one per cycle over a valid/ready stream. Each instruction is tagged as 16-bit or 32-bit, and carries a flag for the alternate 16-bit format and a flag for a bad pointer. When a block reserves immediate space, the whole block is copied into a holding register. Operand logic reads that copy through a combinational slot-read port. Blocks that reserve nothing leave the copy as it was, so later code keeps resolving its operands against the most recent reserving block.

The control is a three-state machine. `ST_IDLE` waits for a block. `ST_ISSUE` emits the current slot, or the current half of a pair. `ST_DUP` emits the duplicate. The transitions are:
- accept: `ST_IDLE`→`ST_ISSUE`, on a block handshake.
- next-half: `ST_ISSUE`→`ST_ISSUE`, after the first half of a pair.
- advance: `ST_ISSUE`→`ST_ISSUE`, on to the next slot.
- branch-dup: `ST_ISSUE`→`ST_DUP`, after a legal pointer instruction.
- dup-return: `ST_DUP`→`ST_ISSUE`, on to the next slot.
- finish: `ST_ISSUE`/`ST_DUP`→`ST_IDLE`, after the last issuable slot.

Top module: `csq_seq`

## Requirements
- R1: After reset, `blk_ready` is 1, `ins_valid` is 0 and every slot read through the retained-block port is zero.
- R2: A slot with bit 16 set is a pair. It is issued as two 16-bit instructions, bits [31:16] first and then bits [15:0]. Each sits in `ins_data[15:0]` with the upper bits zero and `ins_is16`=1. A slot with bit 16 clear is issued as one 32-bit instruction with `ins_is16`=0.
- R3: An operate instruction has bits [31:26] = 6'b000001 and bit 16 = 0, and its 3-bit field is bits [2:0]. If slot 0 is an operate instruction with a nonzero field N, the last N slots (8-N to 7) are reserved and not issued. Slots 0 to 7-N are issued in ascending order. Otherwise all eight slots are issued.
- R4: An operate instruction in slot s≥1 with a nonzero field t that is legal is followed directly by a duplicate of slot t. The duplicate is the whole slot if slot t is 32-bit, or only its bits [31:16] as a 16-bit instruction if slot t is a pair.
- R5: A pointer may name the first reserved slot (t = 8-N). The duplicate is then that slot's bits [31:16] as a 16-bit instruction, with `ins_fmt` equal to the slot's bit 31. Every other issued instruction has `ins_fmt`=0.
- R6: A pointer is illegal if t = s, or if N>0 and t > 8-N. The pointer instruction is then issued with `ins_err`=1 and no duplicate follows. Every other instruction has `ins_err`=0.
- R7: When an accepted block has N≠0, all of it is stored. `imm_rd_data` returns slot `imm_rd_idx` of the stored copy combinationally. A block with N=0 leaves the stored copy unchanged.
- R8: While `ins_valid`=1 and `ins_ready`=0, `ins_valid`, `ins_data`, `ins_is16`, `ins_fmt` and `ins_err` hold their values.
- R9: `blk_ready` is 1 only while no instruction is pending. It rises in the cycle after the handshake of the last instruction of a block, including any duplicate. The first instruction is valid in the cycle after a block is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | Code block offered |
| blk_ready | output | 1 | Sequencer idle, can take a block |
| blk_data | input | 256 | Code block, slot k in bits [32k+31:32k] |
| ins_valid | output | 1 | Instruction available |
| ins_ready | input | 1 | Consumer takes the instruction |
| ins_data | output | 32 | Instruction, 16-bit ones zero-extended |
| ins_is16 | output | 1 | Instruction is 16-bit |
| ins_fmt | output | 1 | Alternate 16-bit format selected by bit 31 |
| ins_err | output | 1 | Instruction carries an illegal slot pointer |
| imm_rd_idx | input | 3 | Slot index into the retained block |
| imm_rd_data | output | 32 | Slot word of the retained block |

## Verification
The bench sweeps every reserve count against every pointer source and target slot. Pairs and 32-bit words are mixed at varying positions. Back-pressure is applied in some sweeps.

It aims at the boundary between the last issuable slot and the first reserved slot. A design that got this wrong would issue immediate data as code, drop the last real slot, or reject the first-reserved target. It also checks self-pointers and pointers beyond the first reserved slot; a faulty design would emit a duplicate there or miss the error flag. Pair targets must yield only their upper half, and a miscounting design would emit both halves. Finally, it checks the retained block after a non-reserving block; a faulty design would overwrite the operand copy.

// File: rtl/csq_pkg.sv
package csq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DUP   = 2'd2
    } csq_state_e;

    localparam int OPC_W = 6;
    localparam logic [OPC_W-1:0] OPC_OPERATE = 6'b000001;
endpackage

// File: rtl/csq_slot_dec.sv
module csq_slot_dec #(
    parameter int SLOT_W = 32,
    parameter int PTR_W  = 3
) (
    input  logic [SLOT_W-1:0] word,
    output logic              is_pair,
    output logic              is_oper,
    output logic [PTR_W-1:0]  fld
);
    import csq_pkg::*;
    localparam int HALF_W = SLOT_W / 2;

    always_comb begin
        is_pair = word[HALF_W];
        is_oper = !word[HALF_W] && (word[SLOT_W-1 -: OPC_W] == OPC_OPERATE);
        fld     = word[PTR_W-1:0];
    end
endmodule

// File: rtl/csq_imm_hold.sv
module csq_imm_hold #(
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 8,
    parameter int PTR_W     = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [SLOT_W*NUM_SLOTS-1:0] blk_in,
    input  logic [PTR_W-1:0]            rd_idx,
    output logic [SLOT_W-1:0]           rd_data
);
    localparam int BLK_W = SLOT_W * NUM_SLOTS;

    logic [BLK_W-1:0]  store_q;
    logic [SLOT_W-1:0] view [NUM_SLOTS];

    always_ff @(posedge clk) begin
        if (!rst_n)    store_q <= '0;
        else if (load) store_q <= blk_in;
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_view
        assign view[g] = store_q[g*SLOT_W +: SLOT_W];
    end

    assign rd_data = view[rd_idx];

    // R7: a block without reserved space never disturbs the retained copy
    a_r7_keep_unless_load: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(store_q));
endmodule

// File: rtl/csq_seq.sv
module csq_seq #(
    parameter int SLOT_W    = 32,
    parameter int NUM_SLOTS = 8,
    parameter int PTR_W     = $clog2(NUM_SLOTS),
    parameter int BLK_W     = SLOT_W * NUM_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_valid,
    output logic              blk_ready,
    input  logic [BLK_W-1:0]  blk_data,
    output logic              ins_valid,
    input  logic              ins_ready,
    output logic [SLOT_W-1:0] ins_data,
    output logic              ins_is16,
    output logic              ins_fmt,
    output logic              ins_err,
    input  logic [PTR_W-1:0]  imm_rd_idx,
    output logic [SLOT_W-1:0] imm_rd_data
);
    import csq_pkg::*;

    localparam int HALF_W = SLOT_W / 2;
    localparam int CNT_W  = PTR_W + 1;

    csq_state_e        state_q, state_n;
    logic [BLK_W-1:0]  blk_q;
    logic [PTR_W-1:0]  slot_q, slot_n;
    logic              half_q, half_n;
    logic [PTR_W-1:0]  rsv_q;

    // decode of the held block, one decoder per slot
    logic [SLOT_W-1:0] slot_a   [NUM_SLOTS];
    logic              pair_a   [NUM_SLOTS];
    logic              oper_a   [NUM_SLOTS];
    logic [PTR_W-1:0]  fld_a    [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_dec
        assign slot_a[g] = blk_q[g*SLOT_W +: SLOT_W];
        csq_slot_dec #(.SLOT_W(SLOT_W), .PTR_W(PTR_W)) u_dec (
            .word    (slot_a[g]),
            .is_pair (pair_a[g]),
            .is_oper (oper_a[g]),
            .fld     (fld_a[g])
        );
    end

    // decode of slot 0 of the incoming block for its reserve count
    logic             in_pair, in_oper;
    logic [PTR_W-1:0] in_fld, in_rsv;
    csq_slot_dec #(.SLOT_W(SLOT_W), .PTR_W(PTR_W)) u_in_dec (
        .word    (blk_data[SLOT_W-1:0]),
        .is_pair (in_pair),
        .is_oper (in_oper),
        .fld     (in_fld)
    );
    assign in_rsv = in_oper ? in_fld : '0;

    logic blk_fire, ins_fire;
    assign blk_fire = blk_valid && blk_ready;
    assign ins_fire = ins_valid && ins_ready;

    csq_imm_hold #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .PTR_W(PTR_W)) u_imm (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (blk_fire && (in_rsv != '0)),
        .blk_in  (blk_data),
        .rd_idx  (imm_rd_idx),
        .rd_data (imm_rd_data)
    );

    // slot bookkeeping for the current block
    logic [SLOT_W-1:0] cur_word, tgt_word;
    logic [PTR_W-1:0]  last_slot, ptr;
    logic [CNT_W-1:0]  res_start;
    logic              has_ptr, ptr_bad, tgt_first_res, is_last;

    always_comb begin
        cur_word      = slot_a[slot_q];
        last_slot     = PTR_W'(NUM_SLOTS - 1) - rsv_q;
        res_start     = CNT_W'(NUM_SLOTS) - {1'b0, rsv_q};
        ptr           = fld_a[slot_q];
        has_ptr       = (slot_q != '0) && oper_a[slot_q] && (ptr != '0);
        ptr_bad       = (ptr == slot_q) ||
                        ((rsv_q != '0) && ({1'b0, ptr} > res_start));
        tgt_word      = slot_a[ptr];
        tgt_first_res = (rsv_q != '0) && ({1'b0, ptr} == res_start);
        is_last       = (slot_q == last_slot);
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        slot_n  = slot_q;
        half_n  = half_q;
        unique case (state_q)
            ST_IDLE: begin
                if (blk_valid) begin
                    state_n = ST_ISSUE;
                    slot_n  = '0;
                    half_n  = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (ins_ready) begin
                    if (pair_a[slot_q] && !half_q) begin
                        half_n = 1'b1;
                    end else if (has_ptr && !ptr_bad) begin
                        state_n = ST_DUP;
                    end else if (is_last) begin
                        state_n = ST_IDLE;
                    end else begin
                        slot_n = slot_q + 1'b1;
                        half_n = 1'b0;
                    end
                end
            end
            ST_DUP: begin
                if (ins_ready) begin
                    if (is_last) begin
                        state_n = ST_IDLE;
                    end else begin
                        state_n = ST_ISSUE;
                        slot_n  = slot_q + 1'b1;
                        half_n  = 1'b0;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
            half_q  <= 1'b0;
            rsv_q   <= '0;
            blk_q   <= '0;
        end else begin
            state_q <= state_n;
            slot_q  <= slot_n;
            half_q  <= half_n;
            if (blk_fire) begin
                blk_q <= blk_data;
                rsv_q <= in_rsv;
            end
        end
    end

    // outputs
    always_comb begin
        blk_ready = 1'b0;
        ins_valid = 1'b0;
        ins_data  = '0;
        ins_is16  = 1'b0;
        ins_fmt   = 1'b0;
        ins_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: blk_ready = 1'b1;
            ST_ISSUE: begin
                ins_valid = 1'b1;
                if (pair_a[slot_q]) begin
                    ins_is16 = 1'b1;
                    ins_data = {{HALF_W{1'b0}},
                                half_q ? cur_word[HALF_W-1:0] : cur_word[SLOT_W-1:HALF_W]};
                end else begin
                    ins_data = cur_word;
                    ins_err  = has_ptr && ptr_bad;
                end
            end
            ST_DUP: begin
                ins_valid = 1'b1;
                ins_is16  = tgt_first_res || pair_a[ptr];
                ins_fmt   = tgt_first_res && tgt_word[SLOT_W-1];
                ins_data  = ins_is16 ? {{HALF_W{1'b0}}, tgt_word[SLOT_W-1:HALF_W]} : tgt_word;
            end
            default: blk_ready = 1'b0;
        endcase
    end

    // R8: a stalled instruction holds still
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_data) && $stable(ins_is16)
                                       && $stable(ins_fmt) && $stable(ins_err)));

    // R9: an accepted block always yields at least slot 0 in the next cycle
    a_r9_first_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        blk_fire |=> (ins_valid && !blk_ready));

    // R6: a flagged pointer is never followed by a duplicate
    a_r6_err_no_dup: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_fire && ins_err) |=> (state_q != ST_DUP));

    // R4: a duplicate is entered only right after a 32-bit instruction was taken
    a_r4_dup_follows: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DUP) && ($past(state_q) != ST_DUP)) |-> $past(ins_fire && !ins_is16));

    // R5: the alternate format flag only accompanies 16-bit instructions
    a_r5_fmt_is16: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_fmt) |-> ins_is16);

    // R3: no slot beyond the last issuable one is ever presented
    a_r3_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (slot_q <= last_slot));
endmodule

// File: tb/csq_seq_tb.sv
module csq_seq_tb;
    localparam int SW = 32;
    localparam int NS = 8;
    localparam int BW = SW * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blk_valid = 1'b0;
    logic          blk_ready;
    logic [BW-1:0] blk_data = '0;
    logic          ins_valid;
    logic          ins_ready = 1'b0;
    logic [SW-1:0] ins_data;
    logic          ins_is16, ins_fmt, ins_err;
    logic [2:0]    imm_rd_idx = '0;
    logic [SW-1:0] imm_rd_data;

    always #5 clk = ~clk;

    csq_seq #(.SLOT_W(SW), .NUM_SLOTS(NS)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_data(blk_data),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
        .ins_is16(ins_is16), .ins_fmt(ins_fmt), .ins_err(ins_err),
        .imm_rd_idx(imm_rd_idx), .imm_rd_data(imm_rd_data)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] e_data [64];
    bit          e_16   [64];
    bit          e_fmt  [64];
    bit          e_err  [64];
    bit          e_dup  [64];
    int          ecnt;
    int          exp_n;
    logic [BW-1:0] held = '0;

    function automatic logic [31:0] sl(input logic [BW-1:0] b, input int i);
        return b[i*32 +: 32];
    endfunction

    function automatic bit is_op(input logic [31:0] w);
        return (w[31:26] == 6'b000001) && !w[16];
    endfunction

    function automatic logic [31:0] w_oper(input int i, input int f);
        return 32'h0400_0000 | (32'(i) << 20) | 32'(f & 7);
    endfunction

    function automatic logic [31:0] w_plain(input int i, input int v);
        return 32'hC000_0005 | (32'(i) << 20) | (32'(v & 15) << 8);
    endfunction

    function automatic logic [31:0] w_pair(input int i);
        return {16'h9001 + 16'(i << 4), 16'h5000 + 16'(i)};
    endfunction

    function automatic logic [31:0] w_res(input int i, input int v);
        logic [31:0] w;
        w = (32'h2A5A_3000 ^ (32'(i) << 20)) + 32'(i);
        w[31] = ((i + v) % 2) == 1;
        w[16] = (v % 2) == 1;
        return w;
    endfunction

    function automatic logic [BW-1:0] mk_block(input int n, input int v, input int s, input int t);
        logic [BW-1:0] b;
        for (int i = 0; i < NS; i++) begin
            logic [31:0] w;
            if (i == 0)
                w = (n > 0) ? w_oper(0, n) : ((v % 2) == 1 ? w_oper(0, 0) : w_plain(0, v));
            else if (n > 0 && i >= NS - n)
                w = w_res(i, v);
            else if (i == s)
                w = w_oper(i, t);
            else if (((i + v) % 3) == 0)
                w = w_pair(i);
            else
                w = w_plain(i, v);
            b[i*32 +: 32] = w;
        end
        return b;
    endfunction

    task automatic push(input logic [31:0] d, input bit h, input bit f, input bit e, input bit dp);
        e_data[ecnt] = d; e_16[ecnt] = h; e_fmt[ecnt] = f; e_err[ecnt] = e; e_dup[ecnt] = dp;
        ecnt++;
    endtask

    task automatic build_exp(input logic [BW-1:0] b);
        logic [31:0] s0;
        int first_res;
        ecnt = 0;
        s0 = sl(b, 0);
        exp_n = is_op(s0) ? int'(s0[2:0]) : 0;
        first_res = NS - exp_n;
        for (int i = 0; i <= NS - 1 - exp_n; i++) begin
            logic [31:0] w;
            w = sl(b, i);
            if (w[16]) begin
                push({16'h0, w[31:16]}, 1, 0, 0, 0);
                push({16'h0, w[15:0]}, 1, 0, 0, 0);
            end else if (i != 0 && is_op(w) && w[2:0] != 0) begin
                int t;
                bit bad;
                logic [31:0] tw;
                t = int'(w[2:0]);
                bad = (t == i) || (exp_n != 0 && t > first_res);
                push(w, 0, 0, bad, 0);
                if (!bad) begin
                    tw = sl(b, t);
                    if (exp_n != 0 && t == first_res) push({16'h0, tw[31:16]}, 1, tw[31], 0, 1);
                    else if (tw[16])                  push({16'h0, tw[31:16]}, 1, 0, 0, 1);
                    else                              push(tw, 0, 0, 0, 1);
                end
            end else begin
                push(w, 0, 0, 0, 0);
            end
        end
    endtask

    task automatic check_imm();
        for (int k = 0; k < NS; k++) begin
            imm_rd_idx = 3'(k);
            #1;
            checks++;
            if (imm_rd_data !== sl(held, k)) begin
                fails++;
                $display("FAIL R7 retained slot %0d actual=%h expected=%h", k, imm_rd_data, sl(held, k));
            end
        end
    endtask

    task automatic run_block(input logic [BW-1:0] b, input int rmode);
        int idx;
        int cyc;
        bit stalled;
        logic [SW-1:0] sv_d;
        logic [2:0]    sv_f;
        build_exp(b);
        @(negedge clk);
        blk_data = b; blk_valid = 1'b1; ins_ready = 1'b0;
        #1;
        checks++;
        if (blk_ready !== 1'b1 || ins_valid !== 1'b0) begin
            fails++;
            $display("FAIL R9 not idle before block actual=%b%b expected=10", blk_ready, ins_valid);
        end
        @(negedge clk);
        blk_valid = 1'b0;
        idx = 0; cyc = 0; stalled = 0; sv_d = '0; sv_f = '0;
        while (idx < ecnt && cyc < 200) begin
            ins_ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
            #1;
            if (stalled) begin
                checks++;
                if (ins_valid !== 1'b1 || ins_data !== sv_d || {ins_is16, ins_fmt, ins_err} !== sv_f) begin
                    fails++;
                    $display("FAIL R8 stall moved actual=%b %h expected=1 %h", ins_valid, ins_data, sv_d);
                end
                stalled = 0;
            end
            if (ins_valid) begin
                if (ins_ready) begin
                    checks++;
                    if (ins_data !== e_data[idx] || ins_is16 !== e_16[idx] ||
                        ins_fmt !== e_fmt[idx] || ins_err !== e_err[idx]) begin
                        fails++;
                        $display("FAIL %s beat %0d actual=%h/%b%b%b expected=%h/%b%b%b",
                                 e_err[idx] ? "R6" : e_fmt[idx] ? "R5" : e_dup[idx] ? "R4" :
                                 e_16[idx] ? "R2" : "R3", idx,
                                 ins_data, ins_is16, ins_fmt, ins_err,
                                 e_data[idx], e_16[idx], e_fmt[idx], e_err[idx]);
                    end
                    idx++;
                end else begin
                    stalled = 1;
                    sv_d = ins_data;
                    sv_f = {ins_is16, ins_fmt, ins_err};
                end
            end
            cyc++;
            @(negedge clk);
        end
        ins_ready = 1'b0;
        if (idx < ecnt) begin
            fails++;
            $display("FAIL R9 block stream stopped actual=%0d beats expected=%0d", idx, ecnt);
        end
        #1;
        checks++;
        if (ins_valid !== 1'b0 || blk_ready !== 1'b1) begin
            fails++;
            $display("FAIL R9 end of block actual=valid%b ready%b expected=valid0 ready1", ins_valid, blk_ready);
        end
        if (exp_n != 0) held = b;
        check_imm();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (blk_ready !== 1'b1 || ins_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state actual=%b%b expected=10", blk_ready, ins_valid);
        end
        check_imm();

        // R3, R2, R7: every reserve count with mixed slot kinds, no pointers
        for (int n = 0; n < NS; n++)
            for (int v = 0; v < 4; v++)
                run_block(mk_block(n, v, 0, 0), v % 2);

        // R4, R5, R6: every pointer source against every target for each reserve count
        for (int n = 0; n < NS; n++)
            for (int s = 1; s <= NS - 1 - n; s++)
                for (int t = 1; t < NS; t++)
                    for (int v = 0; v < 2; v++)
                        run_block(mk_block(n, v + 2 * (t % 2), s, t), (s + t) % 2);

        // R7: non-reserving block after a reserving one keeps the copy
        run_block(mk_block(3, 1, 2, 5), 0);
        run_block(mk_block(0, 0, 1, 6), 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule